// File: doc/BRIEF.md
# SPI Flash Boot Copier

This block copies a program image from a serial flash into a 32-bit memory after reset. It talks to the flash as an SPI master and to the memory as a Wishbone write master. During the copy it keeps the processor and its peripherals in reset through a dedicated hold line. Once the last word has been written to memory, it releases that line and the processor starts from a memory that is already loaded.

Once reset is released, the block samples its enable input. With enable high it pulls chip select low and sends the read opcode 0x03, followed by a 24-bit flash start address. It then clocks in the requested number of bytes. Every four bytes form one word, with the first byte in the most significant position. Each word is written to consecutive word addresses, starting at a base address set by a parameter. The serial clock runs at the system clock divided by a parameter. If a new word is complete while the previous write has not yet been acknowledged, the serial clock pauses. With enable low the block does no copying and behaves as if the copy had already finished.

Top module: `spi_boot_copier`

## Requirements
- R1: `cpu_hold` is high whenever `rst` is high. After reset is released with enable high, it stays high until the final memory write is acknowledged, and it goes low no later than 4 clock cycles after the cycle in which that final acknowledge is sampled.
- R2: `enable` is sampled in the first cycle after reset is released. If it is low, `cpu_hold` goes low within 2 cycles, `spi_cs_n` stays high, `spi_sclk` stays low, and no memory strobe or cycle is raised until the next reset.
- R3: A copy drives `spi_cs_n` low for one unbroken burst. The burst starts with byte 0x03, followed by `FLASH_START` as 24 bits, most significant bit first, and is followed by the data bytes. `spi_sclk` is low whenever `spi_cs_n` is high. Each high phase of `spi_sclk` lasts `CLK_DIV - CLK_DIV/2` system clocks. `spi_cs_n` is high once the copy has finished.
- R4: `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is captured at the rising edge of `spi_sclk`.
- R5: Flash byte k of the image (k counting from 0) lands in word k/4. Byte 4i+0 goes to bits 31:24, 4i+1 to bits 23:16, 4i+2 to bits 15:8 and 4i+3 to bits 7:0.
- R6: Word i is written to address `MEM_BASE + i`, for i = 0 to `WORD_COUNT-1`, in that order. Every strobe has `mem_we` = 1 and `mem_sel` = 4'hF. The strobe, address and data are held until `mem_ack` is seen.
- R7: `mem_stb` is high only while `mem_cyc` is high. `mem_cyc` stays high from the first write of a copy through the acknowledge of the last write.
- R8: `mem_rst` equals `rst`, and `mem_clk` equals `clk`.
- R9: A reset during a copy returns the block to its reset state: `spi_cs_n` high, no strobe or cycle, and `cpu_hold` high. After the reset is released, the copy starts again from the first flash byte and the first word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the copy after reset when high |
| cpu_hold | output | 1 | Holds processor and peripherals in reset |
| spi_sclk | output | 1 | Serial clock to flash |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| mem_clk | output | 1 | Copy of the system clock for the memory |
| mem_rst | output | 1 | Copy of the reset for the memory |
| mem_cyc | output | 1 | Bus cycle, spanning the whole copy |
| mem_stb | output | 1 | Transfer strobe |
| mem_we | output | 1 | Write enable |
| mem_sel | output | 4 | Byte lane selects |
| mem_adr | output | 20 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer acknowledge |

## Verification
A wrong byte counter or a wrong lane position appears at the memory port on the first write. The bench catches it as a wrong address or wrong packed data within about 4 serial bytes of the header. A state machine that leaves the copy too early or too late shows up in `cpu_hold`: the line falls while expected writes are still outstanding, or it is still high 5 cycles after the final acknowledge. A broken divider or shifter shows up at once on the SPI pins, through a header that does not match, serial data that moves during a high clock phase, or high phases of the wrong length.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_DRAIN,
    ST_DONE
  } boot_state_t;

  localparam logic [7:0] FLASH_READ_OP = 8'h03;
  localparam int unsigned HDR_BYTES    = 4;

endpackage

// File: rtl/spi_byte_xfer.sv
// One byte, shifted out and in at the same time, in SPI mode 0. The clock idles low between bytes.
module spi_byte_xfer #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int unsigned LOW_CYC  = CLK_DIV / 2;
  localparam int unsigned HIGH_CYC = CLK_DIV - LOW_CYC;
  localparam int unsigned CNT_W    = $clog2(CLK_DIV + 1);

  logic [CNT_W-1:0] phase_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;
  logic             busy_q;
  logic             sclk_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          tx_q    <= tx_byte;
          phase_q <= '0;
          bit_q   <= '0;
        end
      end else if (!sclk_q) begin
        if (phase_q == CNT_W'(LOW_CYC - 1)) begin
          phase_q <= '0;
          sclk_q  <= 1'b1;
          rx_q    <= {rx_q[6:0], miso};
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end else begin
        if (phase_q == CNT_W'(HIGH_CYC - 1)) begin
          phase_q <= '0;
          sclk_q  <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];

endmodule

// File: rtl/word_packer.sv
// Packs bytes into a word, the first byte landing in the top lane.
module word_packer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  output logic              word_valid,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane_q;
  logic [DATA_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (byte_valid) begin
        word_q <= {word_q[DATA_W-9:0], byte_in};
        if (lane_q == LANE_W'(LANES - 1)) begin
          lane_q  <= '0;
          valid_q <= 1'b1;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  assign word_valid = valid_q;
  assign word       = word_q;

endmodule

// File: rtl/wb_word_writer.sv
// Writes one full word at a time. The cycle signal follows the session input.
module wb_word_writer #(
  parameter int unsigned      ADDR_W   = 20,
  parameter int unsigned      DATA_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                session,
  input  logic                load,
  input  logic [DATA_W-1:0]   word,
  input  logic                ack,
  output logic                busy,
  output logic                done,
  output logic                cyc,
  output logic                stb,
  output logic                we,
  output logic [DATA_W/8-1:0] sel,
  output logic [ADDR_W-1:0]   adr,
  output logic [DATA_W-1:0]   dat
);
  localparam int unsigned SEL_W = DATA_W / 8;

  logic              cyc_q;
  logic              stb_q;
  logic              we_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] dat_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= 1'b0;
      stb_q  <= 1'b0;
      we_q   <= 1'b0;
      sel_q  <= '0;
      adr_q  <= MEM_BASE;
      dat_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cyc_q  <= session;
      done_q <= 1'b0;
      if (stb_q && ack) begin
        stb_q  <= 1'b0;
        we_q   <= 1'b0;
        sel_q  <= '0;
        adr_q  <= adr_q + 1'b1;
        done_q <= 1'b1;
      end else if (load && !stb_q) begin
        stb_q <= 1'b1;
        we_q  <= 1'b1;
        sel_q <= '1;
        dat_q <= word;
      end
    end
  end

  assign busy = stb_q;
  assign done = done_q;
  assign cyc  = cyc_q;
  assign stb  = stb_q;
  assign we   = we_q;
  assign sel  = sel_q;
  assign adr  = adr_q;
  assign dat  = dat_q;

endmodule

// File: rtl/spi_boot_copier.sv
module spi_boot_copier
  import spi_boot_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 20,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       WORD_COUNT  = 16,
  parameter int unsigned       CLK_DIV     = 4,
  parameter logic [23:0]       FLASH_START = 24'h100000,
  parameter logic [ADDR_W-1:0] MEM_BASE    = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  output logic                cpu_hold,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic                spi_cs_n,
  output logic                mem_clk,
  output logic                mem_rst,
  output logic                mem_cyc,
  output logic                mem_stb,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_sel,
  output logic [ADDR_W-1:0]   mem_adr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack
);
  localparam int unsigned LANES      = DATA_W / 8;
  localparam int unsigned LANE_W     = $clog2(LANES);
  localparam int unsigned BYTE_TOTAL = WORD_COUNT * LANES;
  localparam int unsigned BCNT_W     = $clog2(BYTE_TOTAL + 1);
  localparam int unsigned WCNT_W     = $clog2(WORD_COUNT + 1);
  localparam int unsigned HDR_W      = $clog2(HDR_BYTES);

  boot_state_t       state_q;
  logic [HDR_W-1:0]  hdr_idx_q;
  logic              hdr_all_q;
  logic [BCNT_W-1:0] bytes_q;
  logic [WCNT_W-1:0] words_q;
  logic              hold_q;
  logic              cs_n_q;

  logic              xfer_start;
  logic [7:0]        xfer_tx;
  logic              xfer_busy;
  logic              xfer_done;
  logic [7:0]        xfer_rx;
  logic              pk_in_valid;
  logic              pk_valid;
  logic [DATA_W-1:0] pk_word;
  logic              wr_busy;
  logic              wr_done;
  logic              session;
  logic              next_last_lane;
  logic              bytes_left;

  assign next_last_lane = bytes_q[LANE_W-1:0] == LANE_W'(LANES - 1);
  assign bytes_left     = bytes_q != BCNT_W'(BYTE_TOTAL);
  assign session        = (state_q == ST_DATA) || (state_q == ST_DRAIN);
  assign pk_in_valid    = xfer_done && (state_q == ST_DATA);

  // Byte issue: the header goes out first, then filler bytes while data is read. The last lane of a word waits for the memory writer to be free.
  always_comb begin
    xfer_start = 1'b0;
    xfer_tx    = 8'h00;
    case (state_q)
      ST_CMD: begin
        if (!xfer_busy && !hdr_all_q) begin
          xfer_start = 1'b1;
          case (hdr_idx_q)
            HDR_W'(0): xfer_tx = FLASH_READ_OP;
            HDR_W'(1): xfer_tx = FLASH_START[23:16];
            HDR_W'(2): xfer_tx = FLASH_START[15:8];
            default:   xfer_tx = FLASH_START[7:0];
          endcase
        end
      end
      ST_DATA: begin
        if (!xfer_busy && bytes_left && !(next_last_lane && wr_busy)) begin
          xfer_start = 1'b1;
        end
      end
      default: begin
        xfer_start = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      hdr_idx_q <= '0;
      hdr_all_q <= 1'b0;
      bytes_q   <= '0;
      words_q   <= '0;
      hold_q    <= 1'b1;
      cs_n_q    <= 1'b1;
    end else begin
      if (wr_done) begin
        words_q <= words_q + 1'b1;
      end
      case (state_q)
        ST_IDLE: begin
          if (enable) begin
            state_q <= ST_CMD;
            cs_n_q  <= 1'b0;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_CMD: begin
          if (xfer_start) begin
            hdr_idx_q <= hdr_idx_q + 1'b1;
            if (hdr_idx_q == HDR_W'(HDR_BYTES - 1)) begin
              hdr_all_q <= 1'b1;
            end
          end
          if (hdr_all_q && xfer_done) begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (xfer_start) begin
            bytes_q <= bytes_q + 1'b1;
          end
          if (!bytes_left && xfer_done) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (words_q == WCNT_W'(WORD_COUNT)) begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          hold_q <= 1'b0;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  spi_byte_xfer #(
    .CLK_DIV (CLK_DIV)
  ) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .start   (xfer_start),
    .tx_byte (xfer_tx),
    .miso    (spi_miso),
    .busy    (xfer_busy),
    .done    (xfer_done),
    .rx_byte (xfer_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  word_packer #(
    .DATA_W (DATA_W)
  ) u_packer (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (pk_in_valid),
    .byte_in    (xfer_rx),
    .word_valid (pk_valid),
    .word       (pk_word)
  );

  wb_word_writer #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MEM_BASE (MEM_BASE)
  ) u_writer (
    .clk     (clk),
    .rst     (rst),
    .session (session),
    .load    (pk_valid),
    .word    (pk_word),
    .ack     (mem_ack),
    .busy    (wr_busy),
    .done    (wr_done),
    .cyc     (mem_cyc),
    .stb     (mem_stb),
    .we      (mem_we),
    .sel     (mem_sel),
    .adr     (mem_adr),
    .dat     (mem_wdata)
  );

  assign cpu_hold = rst | hold_q;
  assign spi_cs_n = cs_n_q;
  assign mem_clk  = clk;
  assign mem_rst  = rst;

endmodule

// File: rtl/spi_boot_copier_chk.sv
module spi_boot_copier_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                cpu_hold,
  input logic                spi_sclk,
  input logic                spi_mosi,
  input logic                spi_cs_n,
  input logic                mem_cyc,
  input logic                mem_stb,
  input logic                mem_we,
  input logic [DATA_W/8-1:0] mem_sel,
  input logic [ADDR_W-1:0]   mem_adr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_ack
);

  AST_HOLD_IN_RESET: assert property (@(posedge clk) rst |-> cpu_hold); // R1

  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |-> (spi_cs_n && !mem_cyc && !mem_stb)); // R2

  AST_SCLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R3

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R4

  AST_FULL_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_stb |-> (mem_we && (mem_sel == '1))); // R6

  AST_STB_HELD_TO_ACK: assert property (@(posedge clk) disable iff (rst)
    (mem_stb && !mem_ack) |=> (mem_stb && $stable(mem_adr) && $stable(mem_wdata))); // R6

  AST_STB_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_stb |-> mem_cyc); // R7

endmodule

bind spi_boot_copier spi_boot_copier_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_hold  (cpu_hold),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n),
  .mem_cyc   (mem_cyc),
  .mem_stb   (mem_stb),
  .mem_we    (mem_we),
  .mem_sel   (mem_sel),
  .mem_adr   (mem_adr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/spi_boot_copier_bench.sv
module spi_boot_copier_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          WC         = 5;
  localparam int          DIV        = 4;
  localparam int          HIGH_EXP   = DIV - DIV / 2;
  localparam logic [23:0] FS         = 24'h0A1B2C;
  localparam logic [19:0] MB         = 20'h00400;
  localparam int          WATCHDOG   = 150000;

  typedef struct packed {
    logic [19:0] adr;
    logic [31:0] dat;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic        spi_miso = 1'b0;
  logic        mem_ack = 1'b0;
  logic        cpu_hold, spi_sclk, spi_mosi, spi_cs_n;
  logic        mem_clk, mem_rst, mem_cyc, mem_stb, mem_we;
  logic [3:0]  mem_sel;
  logic [19:0] mem_adr;
  logic [31:0] mem_wdata;

  int checks = 0;
  int failures = 0;
  int cyc_cnt = 0;
  int writes = 0;
  int wait_ctr = 0;
  int probe_at = -1;
  int hold_err = 0;
  int cyc_err = 0;
  int mosi_err = 0;
  int sclk_err = 0;
  int hi_len = 0;
  int fbit = 0;
  int hdr_seen = 0;
  bit in_burst = 0;
  bit run_active = 0;
  logic prev_sclk = 1'b0;
  logic prev_mosi = 1'b0;
  logic [31:0] hdr = '0;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_boot_copier #(
    .ADDR_W      (20),
    .DATA_W      (32),
    .WORD_COUNT  (WC),
    .CLK_DIV     (DIV),
    .FLASH_START (FS),
    .MEM_BASE    (MB)
  ) u_spi_boot_copier (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cpu_hold  (cpu_hold),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n),
    .mem_clk   (mem_clk),
    .mem_rst   (mem_rst),
    .mem_cyc   (mem_cyc),
    .mem_stb   (mem_stb),
    .mem_we    (mem_we),
    .mem_sel   (mem_sel),
    .mem_adr   (mem_adr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: expected memory image for one copy (R5, R6)
  task automatic push_image();
    exp_t e;
    for (int i = 0; i < WC; i++) begin
      e.adr = MB + 20'(i);
      e.dat = {fbyte(FS + 24'(4 * i)),     fbyte(FS + 24'(4 * i + 1)),
               fbyte(FS + 24'(4 * i + 2)), fbyte(FS + 24'(4 * i + 3))};
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_copy(input string req);
    int t = 0;
    while ((exp_q.size() != 0 || cpu_hold) && t < 20000) begin
      tick(1);
      t++;
    end
    check(t < 20000, req, "copy did not finish", 64'(t), 64'(20000));
  endtask

  // Flash model: read header on rising sclk, data driven on falling sclk
  always @(negedge spi_cs_n) fbit = 0;

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (fbit < 32) hdr = {hdr[30:0], spi_mosi};
      fbit++;
      if (fbit == 32) begin
        hdr_seen++;
        check(hdr[31:24] == 8'h03, "R3", "read opcode", 64'(hdr[31:24]), 64'h03);
        check(hdr[23:0] == FS, "R3", "flash start address", 64'(hdr[23:0]), 64'(FS));
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && fbit >= 32) begin
      int n;
      logic [7:0] b;
      n = fbit - 32;
      b = fbyte(FS + 24'(n / 8));
      spi_miso = b[7 - (n % 8)];
    end
  end

  // Monitor and memory responder, scoreboard pop
  always @(negedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, WATCHDOG);
      summary();
      $finish;
    end
    if (rst) begin
      hi_len = 0;
      in_burst = 0;
      mem_ack = 1'b0;
      wait_ctr = 0;
    end else begin
      if (spi_sclk) hi_len++;
      else begin
        if (prev_sclk && hi_len != HIGH_EXP) sclk_err++;
        hi_len = 0;
      end
      if (prev_sclk && spi_sclk && spi_mosi !== prev_mosi) mosi_err++;
      if (run_active && exp_q.size() > 0 && !cpu_hold) hold_err++;
      if (in_burst && !mem_cyc) cyc_err++;
      if (probe_at == cyc_cnt) begin
        check(cpu_hold == 1'b0, "R1", "hold after final ack", 64'(cpu_hold), 64'(0));
        check(spi_cs_n == 1'b1, "R3", "cs_n after copy", 64'(spi_cs_n), 64'(1));
      end
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_stb) begin
        if (wait_ctr != 0) wait_ctr--;
        else begin
          exp_t e;
          mem_ack = 1'b1;
          writes++;
          in_burst = 1;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected write", 64'(mem_adr), 64'(0));
          end else begin
            e = exp_q.pop_front();
            check(mem_adr == e.adr, "R6", "write address", 64'(mem_adr), 64'(e.adr));
            check(mem_wdata == e.dat, "R5", "packed word", 64'(mem_wdata), 64'(e.dat));
            check(mem_we && mem_sel == 4'hF, "R6", "we/sel", 64'({mem_we, mem_sel}), 64'h1F);
            check(cpu_hold, "R1", "hold during write", 64'(cpu_hold), 64'(1));
            if (exp_q.size() == 0) begin
              in_burst = 0;
              probe_at = cyc_cnt + 5;
            end
          end
          wait_ctr = writes % 4;
        end
      end
    end
    prev_sclk = rst ? 1'b0 : spi_sclk;
    prev_mosi = spi_mosi;
  end

  initial begin
    int base;
    int activity;
    tick(4);
    // Reset state
    check(cpu_hold == 1'b1, "R1", "hold in reset", 64'(cpu_hold), 64'(1));
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R9", "spi idle in reset",
          64'({spi_cs_n, spi_sclk}), 64'h2);
    check(mem_cyc == 1'b0 && mem_stb == 1'b0, "R9", "bus idle in reset",
          64'({mem_cyc, mem_stb}), 64'h0);
    check(mem_rst == 1'b1 && mem_clk == clk, "R8", "mem reset/clock in reset",
          64'({mem_rst, mem_clk}), 64'({1'b1, clk}));

    // Full copy
    push_image();
    run_active = 1;
    rst = 1'b0;
    wait_copy("R1");
    tick(8);
    check(writes == WC, "R6", "write count", 64'(writes), 64'(WC));
    check(hdr_seen == 1, "R3", "header count", 64'(hdr_seen), 64'(1));
    check(mem_rst == 1'b0, "R8", "mem reset released", 64'(mem_rst), 64'(0));
    #2;
    check(mem_clk == clk, "R8", "mem clock follows clk", 64'(mem_clk), 64'(clk));

    // Reset from finished state, then abort mid copy
    @(negedge clk);
    rst = 1'b1;
    #1;
    check(cpu_hold == 1'b1 && mem_rst == 1'b1, "R1", "hold/mem_rst follow reset",
          64'({cpu_hold, mem_rst}), 64'h3);
    tick(2);
    push_image();
    rst = 1'b0;
    begin
      int t = 0;
      while (exp_q.size() > WC - 2 && t < 20000) begin tick(1); t++; end
    end
    rst = 1'b1;
    tick(3);
    check(spi_cs_n == 1'b1 && mem_cyc == 1'b0 && mem_stb == 1'b0 && cpu_hold == 1'b1,
          "R9", "abort state", 64'({spi_cs_n, mem_cyc, mem_stb, cpu_hold}), 64'h9);
    exp_q.delete();
    push_image();
    base = writes;
    rst = 1'b0;
    wait_copy("R9");
    tick(8);
    check(writes - base == WC, "R9", "restart write count", 64'(writes - base), 64'(WC));

    // Enable low: no copy
    enable = 1'b0;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(3);
    check(cpu_hold == 1'b0, "R2", "hold released without copy", 64'(cpu_hold), 64'(0));
    base = writes;
    activity = 0;
    repeat (300) begin
      tick(1);
      if (!spi_cs_n || spi_sclk || mem_cyc || mem_stb) activity++;
    end
    check(activity == 0, "R2", "bus activity with enable low", 64'(activity), 64'(0));
    check(writes == base, "R2", "writes with enable low", 64'(writes - base), 64'(0));

    // Enable high again: another full copy
    enable = 1'b1;
    rst = 1'b1;
    tick(3);
    push_image();
    base = writes;
    rst = 1'b0;
    wait_copy("R1");
    tick(8);
    check(writes - base == WC, "R6", "second copy write count", 64'(writes - base), 64'(WC));

    check(hold_err == 0, "R1", "hold low during copy", 64'(hold_err), 64'(0));
    check(cyc_err == 0, "R7", "cyc dropped inside burst", 64'(cyc_err), 64'(0));
    check(mosi_err == 0, "R4", "mosi moved while sclk high", 64'(mosi_err), 64'(0));
    check(sclk_err == 0, "R3", "sclk high phase length", 64'(sclk_err), 64'(0));
    summary();
    $finish;
  end

endmodule